// File: doc/BRIEF.md
# Toggle-Write Memory Cycle Controller

This block sits in front of a non-volatile word array whose cells cannot be forced to a value; a cell can only be flipped. Every access begins on a rising edge of a chip-select input. The input is already synchronised to the free-running system clock. That edge captures the address and the write-enable level. A short chip-select pulse is treated as a glitch and dropped. A pulse that stays high long enough is accepted as a cycle.

A read cycle fetches the addressed word and presents it on the data output. The output enable controls whether the data bus is driven. A write cycle waits for a commit strobe, then reads the stored word, forms the difference against the new data, and flips only the differing bits. Two active-low inhibit inputs each guard one half of the address space, so either half can be frozen as read-only memory. The cell array here is a behavioural toggle-only register model. In this model the array clears on reset.

Top module: `tglmem_ctrl`

## Requirements
- R1: A cycle's address and write-enable are taken from the clock edge where chip-select is first seen high while the block is idle. Changes to them after that edge have no effect on the cycle.
- R2: A chip-select pulse seen high on fewer than CS_MIN_CYC consecutive clock edges (default 2) is ignored: busy stays low and memory is unchanged.
- R3: For a read (write-enable low at capture), the word appears on dq_out. It is valid two clock edges after the capturing edge. dq_en equals output enable whenever read data is valid, and output enable is used live, never latched.
- R4: For a write (write-enable high at capture), commit is checked on each clock edge after acceptance. While commit is low the write waits and busy stays high. On the first edge where commit is high, dq_in is taken as the write data.
- R5: After a write that is not inhibited, the addressed word equals the write data. The toggle mask holds ones only where the stored word and the data differ. A word is selected by address bit 15 together with the low ARR_IDX_W-1 address bits; the other address bits alias.
- R6: nwi_lo low blocks writes to addresses with bit 15 = 0 (0x0000–0x7FFF). nwi_hi low blocks writes to addresses with bit 15 = 1 (0x8000–0xFFFF). A blocked write leaves the word unchanged.
- R7: A rising edge of chip-select while a cycle is active is ignored. A cycle stays active until at least RD_CYC (read) or WR_CYC (write) clock edges have passed since its capture.
- R8: dq_en is low during any write cycle and whenever no read data is held. The bus is released.
- R9: busy is high from cycle acceptance until read data is valid, or until the toggle step (or inhibit decision) completes. It is low otherwise.
- R10: The inhibit inputs are sampled on the commit edge, not at the chip-select edge.
- R11: After reset, busy and dq_en are low and every word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Synchronised chip-select |
| addr | input | AW | Word address |
| we | input | 1 | Write enable, captured at cycle start |
| oe | input | 1 | Output enable, live |
| commit | input | 1 | Write commit strobe |
| nwi_lo | input | 1 | Active-low write inhibit, lower half |
| nwi_hi | input | 1 | Active-low write inhibit, upper half |
| dq_in | input | DW | Write data |
| dq_out | output | DW | Read data |
| dq_en | output | 1 | Data bus drive enable |
| busy | output | 1 | Cycle in progress |

## Verification
The bench sends single-edge chip-select pulses. A design that miscounts pulse width would accept them and corrupt a word. It also issues writes whose commit arrives late and raises a second chip-select edge in the middle of the wait. A controller that re-captured would land the data at the wrong address or drop the pending write. The bench flips the inhibit lines between the chip-select edge and the commit to expose sampling at the wrong time. It also overwrites random non-zero words, where a design that flips every data-one bit, rather than the differing bits, reads back the wrong value.

// File: rtl/tglmem_pkg.sv
package tglmem_pkg;

    localparam int CNT_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARM,
        S_RD,
        S_WAIT,
        S_WRD,
        S_TOG,
        S_HOLD
    } tgl_state_e;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == {CNT_W{1'b1}}) ? v : v + CNT_W'(1);
    endfunction

endpackage

// File: rtl/tglmem_cs_qual.sv
module tglmem_cs_qual (
    input  logic clk,
    input  logic rst,
    input  logic cs,
    output logic cs_rise
);
    logic cs_q;

    always_ff @(posedge clk) begin
        if (rst) cs_q <= 1'b1;
        else     cs_q <= cs;
    end

    assign cs_rise = cs & ~cs_q;
endmodule

// File: rtl/tglmem_guard.sv
module tglmem_guard (
    input  logic upper_half,
    input  logic nwi_lo,
    input  logic nwi_hi,
    output logic allow
);
    assign allow = upper_half ? nwi_hi : nwi_lo;
endmodule

// File: rtl/tglmem_array.sv
module tglmem_array #(
    parameter int IDX_W = 6,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_word,
    input  logic             tog_en,
    input  logic [IDX_W-1:0] tog_idx,
    input  logic [DW-1:0]    tog_mask
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DW-1:0] cells [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                cells[w] <= '0;
            else if (tog_en && tog_idx == IDX_W'(w))
                cells[w] <= cells[w] ^ tog_mask;
        end
    end

    assign rd_word = cells[rd_idx];
endmodule

// File: rtl/tglmem_ctrl.sv
module tglmem_ctrl
    import tglmem_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int ARR_IDX_W  = 6,
    parameter int CS_MIN_CYC = 2,
    parameter int RD_CYC     = 3,
    parameter int WR_CYC     = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic          oe,
    input  logic          commit,
    input  logic          nwi_lo,
    input  logic          nwi_hi,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_en,
    output logic          busy
);
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(CS_MIN_CYC);
    localparam logic [CNT_W-1:0] RD_C  = CNT_W'(RD_CYC);
    localparam logic [CNT_W-1:0] WR_C  = CNT_W'(WR_CYC);

    tgl_state_e           st;
    logic [AW-1:0]        cap_addr;
    logic                 cap_we;
    logic [CNT_W-1:0]     wcnt;
    logic [CNT_W-1:0]     ccnt;
    logic [DW-1:0]        wdata;
    logic [DW-1:0]        old_word;
    logic [DW-1:0]        rdata;
    logic                 rvalid;

    logic                 cs_rise;
    logic                 allow;
    logic [ARR_IDX_W-1:0] idx;
    logic [DW-1:0]        rd_word;
    logic                 tog_en;
    logic [DW-1:0]        tog_mask;
    logic [CNT_W-1:0]     cyc_len;

    tglmem_cs_qual u_csq (
        .clk     (clk),
        .rst     (rst),
        .cs      (cs),
        .cs_rise (cs_rise)
    );

    tglmem_guard u_guard (
        .upper_half (cap_addr[AW-1]),
        .nwi_lo     (nwi_lo),
        .nwi_hi     (nwi_hi),
        .allow      (allow)
    );

    assign idx      = {cap_addr[AW-1], cap_addr[ARR_IDX_W-2:0]};
    assign tog_en   = (st == S_TOG);
    assign tog_mask = old_word ^ wdata;
    assign cyc_len  = cap_we ? WR_C : RD_C;

    tglmem_array #(.IDX_W(ARR_IDX_W), .DW(DW)) u_arr (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (idx),
        .rd_word  (rd_word),
        .tog_en   (tog_en),
        .tog_idx  (idx),
        .tog_mask (tog_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            cap_addr <= '0;
            cap_we   <= 1'b0;
            wcnt     <= '0;
            ccnt     <= '0;
            wdata    <= '0;
            old_word <= '0;
            rdata    <= '0;
            rvalid   <= 1'b0;
        end else begin
            if (st != S_IDLE) ccnt <= sat_inc(ccnt);
            unique case (st)
                S_IDLE: begin
                    if (cs_rise) begin
                        cap_addr <= addr;
                        cap_we   <= we;
                        wcnt     <= CNT_W'(1);
                        ccnt     <= CNT_W'(1);
                        rvalid   <= 1'b0;
                        st       <= S_ARM;
                    end
                end
                S_ARM: begin
                    if (!cs)
                        st <= S_IDLE;
                    else if ((wcnt + CNT_W'(1)) >= MIN_C)
                        st <= cap_we ? S_WAIT : S_RD;
                    else
                        wcnt <= wcnt + CNT_W'(1);
                end
                S_RD: begin
                    rdata  <= rd_word;
                    rvalid <= 1'b1;
                    st     <= S_HOLD;
                end
                S_WAIT: begin
                    if (commit) begin
                        wdata <= dq_in;
                        st    <= allow ? S_WRD : S_HOLD;
                    end
                end
                S_WRD: begin
                    old_word <= rd_word;
                    st       <= S_TOG;
                end
                S_TOG: st <= S_HOLD;
                S_HOLD: begin
                    if (ccnt >= cyc_len) st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign busy   = (st == S_RD) || (st == S_WAIT) || (st == S_WRD) || (st == S_TOG);
    assign dq_out = rdata;
    assign dq_en  = rvalid & oe;
endmodule

// File: rtl/tglmem_ctrl_chk.sv
module tglmem_ctrl_chk
    import tglmem_pkg::*;
#(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          cs,
    input logic          oe,
    input logic          commit,
    input logic          busy,
    input logic          dq_en,
    input tgl_state_e    st,
    input logic [AW-1:0] cap_addr,
    input logic          tog_en
);
    p_oe_gate_r3: assert property (@(posedge clk) disable iff (rst)
        dq_en |-> oe);

    p_glitch_drop_r2: assert property (@(posedge clk) disable iff (rst)
        (st == S_ARM && !cs) |=> (st == S_IDLE));

    p_commit_wait_r4: assert property (@(posedge clk) disable iff (rst)
        (st == S_WAIT && !commit) |=> (st == S_WAIT && busy));

    p_no_recapture_r7: assert property (@(posedge clk) disable iff (rst)
        (st != S_IDLE) |=> $stable(cap_addr));

    p_toggle_after_read_r5: assert property (@(posedge clk) disable iff (rst)
        tog_en |-> ($past(st) == S_WRD));

    p_bus_released_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !dq_en);
endmodule

bind tglmem_ctrl tglmem_ctrl_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs       (cs),
    .oe       (oe),
    .commit   (commit),
    .busy     (busy),
    .dq_en    (dq_en),
    .st       (st),
    .cap_addr (cap_addr),
    .tog_en   (tog_en)
);

// File: tb/tglmem_ctrl_tb.sv
`timescale 1ns/1ps
module tglmem_ctrl_tb;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int IW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs = 1'b0, we = 1'b0, oe = 1'b0, commit = 1'b0;
    logic          nwi_lo = 1'b1, nwi_hi = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_en, busy;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [DW-1:0] ref_mem [1<<IW];

    tglmem_ctrl u_dut (
        .clk(clk), .rst(rst), .cs(cs), .addr(addr), .we(we), .oe(oe),
        .commit(commit), .nwi_lo(nwi_lo), .nwi_hi(nwi_hi), .dq_in(dq_in),
        .dq_out(dq_out), .dq_en(dq_en), .busy(busy)
    );

    always #10 clk = ~clk;

    function automatic int widx(input logic [AW-1:0] a);
        return int'({a[AW-1], a[IW-2:0]});
    endfunction

    function automatic bit permitted(input logic [AW-1:0] a, input logic lo, input logic hi);
        return a[AW-1] ? hi : lo;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic oe_v,
                      output logic [DW-1:0] d, output logic en, output logic b1);
        @(negedge clk); addr = a; we = 1'b0; cs = 1'b1; oe = oe_v;
        @(negedge clk); addr = ~a;
        @(negedge clk); cs = 1'b0; b1 = busy;
        @(negedge clk); d = dq_out; en = dq_en;
        repeat (5) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); addr = a; we = 1'b1; cs = 1'b1; dq_in = d; commit = 1'b1; oe = 1'b1;
        @(negedge clk);
        @(negedge clk); cs = 1'b0;
        check("R8 dq released in write", {15'd0, dq_en}, 16'd0);
        repeat (8) @(negedge clk);
        commit = 1'b0;
        if (permitted(a, nwi_lo, nwi_hi)) ref_mem[widx(a)] = d;
    endtask

    task automatic rd_check(input logic [AW-1:0] a, input string req);
        logic [DW-1:0] d; logic en, b1;
        rd(a, 1'b1, d, en, b1);
        check(req, d, ref_mem[widx(a)]);
        check("R3 dq_en with oe high", {15'd0, en}, 16'd1);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d; logic en, b1;
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < (1 << IW); i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 busy after reset", {15'd0, busy}, 16'd0);
        check("R11 dq_en after reset", {15'd0, dq_en}, 16'd0);
        rd_check(16'h8123, "R11 zero word after reset");

        // R3 read with live oe, R9 busy, R1 address captured at the edge
        wr(16'h0005, 16'hA5C3);
        rd(16'h0005, 1'b1, d, en, b1);
        check("R1 captured address data", d, 16'hA5C3);
        check("R9 busy during read fetch", {15'd0, b1}, 16'd1);
        check("R9 busy low after read", {15'd0, busy}, 16'd0);
        oe = 1'b0; #1;
        check("R3 dq_en low when oe low", {15'd0, dq_en}, 16'd0);
        oe = 1'b1; #1;
        check("R3 dq_en follows oe rise", {15'd0, dq_en}, 16'd1);

        // R2 single-edge glitch with a write setup
        @(negedge clk); addr = 16'h0005; we = 1'b1; cs = 1'b1; dq_in = 16'hFFFF; commit = 1'b1;
        @(negedge clk); cs = 1'b0;
        @(negedge clk);
        check("R2 glitch leaves busy low", {15'd0, busy}, 16'd0);
        commit = 1'b0;
        repeat (4) @(negedge clk);
        rd_check(16'h0005, "R2 glitch leaves memory");

        // R4 delayed commit, R7 edge ignored during wait
        @(negedge clk); addr = 16'h0007; we = 1'b1; cs = 1'b1; dq_in = 16'h1234; commit = 1'b0;
        @(negedge clk);
        @(negedge clk); cs = 1'b0;
        repeat (10) @(negedge clk);
        check("R4 busy held while commit low", {15'd0, busy}, 16'd1);
        check("R8 dq released while waiting", {15'd0, dq_en}, 16'd0);
        addr = 16'h0009; we = 1'b0; cs = 1'b1;
        @(negedge clk); @(negedge clk); cs = 1'b0;
        @(negedge clk);
        dq_in = 16'h1234; commit = 1'b1;
        repeat (8) @(negedge clk);
        commit = 1'b0;
        ref_mem[widx(16'h0007)] = 16'h1234;
        rd_check(16'h0007, "R4 delayed write lands");
        rd_check(16'h0009, "R7 mid-cycle edge ignored");

        // R6 inhibit per half
        nwi_lo = 1'b0;
        wr(16'h0011, 16'hBEEF);
        rd_check(16'h0011, "R6 lower half blocked");
        wr(16'h8011, 16'hCAFE);
        rd_check(16'h8011, "R6 upper half writable");
        nwi_lo = 1'b1; nwi_hi = 1'b0;
        wr(16'h8011, 16'h0F0F);
        rd_check(16'h8011, "R6 upper half blocked");
        nwi_hi = 1'b1;

        // R10 inhibit sampled at commit
        @(negedge clk); nwi_lo = 1'b0; addr = 16'h0013; we = 1'b1; cs = 1'b1; dq_in = 16'h7777; commit = 1'b0;
        @(negedge clk); @(negedge clk); cs = 1'b0;
        repeat (3) @(negedge clk);
        nwi_lo = 1'b1; commit = 1'b1;
        repeat (8) @(negedge clk);
        commit = 1'b0;
        ref_mem[widx(16'h0013)] = 16'h7777;
        rd_check(16'h0013, "R10 inhibit released before commit");
        @(negedge clk); addr = 16'h8013; we = 1'b1; cs = 1'b1; dq_in = 16'h4444; commit = 1'b0;
        @(negedge clk); @(negedge clk); cs = 1'b0;
        repeat (3) @(negedge clk);
        nwi_hi = 1'b0; commit = 1'b1;
        repeat (8) @(negedge clk);
        commit = 1'b0; nwi_hi = 1'b1;
        rd_check(16'h8013, "R10 inhibit raised before commit");

        // R5 random overwrites of non-zero words with mixed inhibits
        for (int i = 0; i < 60; i++) begin
            logic [AW-1:0] a;
            a = AW'($urandom);
            nwi_lo = ($urandom % 6) != 0;
            nwi_hi = ($urandom % 6) != 0;
            if ($urandom % 2) wr(a, DW'($urandom));
            else rd_check(a, "R5 random readback");
        end
        nwi_lo = 1'b1; nwi_hi = 1'b1;
        wr(16'h0021, 16'hF0F0);
        wr(16'h7FE1, 16'h0FF0);
        rd_check(16'h0021, "R5 alias overwrite with toggle mask");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule